// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Masked Output Writes

This block is a memory-mapped general-purpose I/O controller with four banks of pins. The banks hold 32, 22, 32 and 32 pins, which gives 118 pins in all. Each bank has an output latch, a direction register, an output-enable register and an interrupt mask. The pin states of each bank can be read back through a synchronizer. Software reaches the registers over a plain 32-bit register bus. Reads are combinational and return data in the same cycle as the read strobe. Writes take effect at the clock edge on which the write strobe is sampled.

Output values are never written as a whole word. Each bank exposes two half-word write ports, one for the low sixteen pins and one for the high sixteen. The upper half of the written word is an active-low keep mask for the lower half, so a single pin can be changed atomically without reading the latch first. A pin drives its latched value only when both its direction bit and its enable bit are set. In bank 0, pins 7 and 8 are fixed outputs.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: The banks are 32, 22, 32 and 32 pins wide and are packed contiguously on the pin vectors. Bank 0 occupies pins 0–31, bank 1 occupies 32–53, bank 2 occupies 54–85 and bank 3 occupies 86–117. Bit n of a bank register maps to global pin base+n.
- R2: Bank b has two write-only masked data ports. Byte offset 8*b updates bank pins 0–15, and 8*b+4 updates bank pins 16–31. Both ports read as 0.
- R3: In a masked write, bit 16+i of the write data is a keep flag for pin i of that half, and bit i is the new value. The pin's latch takes the new value only when the keep flag is 0. Otherwise the latch holds its value.
- R4: The read-only pin register at 0x060+4*b returns the bank's pin levels through two flops. An input change sampled at one edge is visible after the second edge. A pin with direction and enable both 1 reads back its latched value instead of the input.
- R5: The direction register at 0x204+0x40*b is read/write. A bit value of 1 selects output.
- R6: The output-enable register at 0x208+0x40*b is read/write. pin_oe is the AND of the direction and enable bits, and pin_out carries the latch. Both change only on a write edge.
- R7: In bank 0, direction bits 7 and 8 always read as 1, and writes of 0 to them are ignored.
- R8: The interrupt mask at 0x20C+0x40*b is read-only. A 1 written at 0x210+0x40*b clears the matching mask bit. A 1 written at 0x214+0x40*b sets the matching mask bit. Both write ports read as 0.
- R9: Register bits at or above a bank's pin count read as 0 and ignore writes. For bank 1 these are bits 31:22.
- R10: After reset, output latches, enable bits and direction bits are 0, except bank 0 direction bits 7 and 8, which are 1. Every implemented interrupt mask bit is 1, and pin_out and pin_oe are all 0.
- R11: rdata is 0 when rd_en is low and for unmapped offsets. Writes to read-only or unmapped offsets change nothing, and one write reaches at most one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| rdata | output | 32 | Read data, 0 when rd_en is low |
| pin_in | input | 118 | Input levels of all pins |
| pin_out | output | 118 | Latched output value of all pins |
| pin_oe | output | 118 | Per-pin driver enable |

## Verification
A masked latch write and an input edge on a different pin of the same bank can land on the same clock edge. They then travel the readback path in different ways. The input edge enters the first synchronizer flop at that same edge. The new latch value enters it only one edge later, because it must first settle in the latch. The bench provokes this by updating pins 7 and 8 of bank 0 and raising input pin 2 in a single cycle. It then reads the bank 0 pin register after one, two and three edges. The expected values are the old word, then the word with only the input change, then the word with both changes.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

  localparam int REG_W       = 32;
  localparam int HALF_W      = 16;
  localparam int DATA_STRIDE = 8;
  localparam int RO_BASE     = 'h060;
  localparam int RO_STRIDE   = 4;
  localparam int CTL_STRIDE  = 'h40;
  localparam int DIR_BASE    = 'h204;
  localparam int OE_BASE     = 'h208;
  localparam int IMASK_BASE  = 'h20C;
  localparam int IEN_BASE    = 'h210;
  localparam int IDIS_BASE   = 'h214;

  // pin count of each bank
  function automatic int bank_pins(input int b);
    case (b)
      1:       return 22;
      default: return 32;
    endcase
  endfunction

  // first global pin of a bank
  function automatic int pin_base(input int b);
    int s;
    s = 0;
    for (int i = 0; i < b; i++) s += bank_pins(i);
    return s;
  endfunction

  function automatic int total_pins(input int nbanks);
    return pin_base(nbanks);
  endfunction

  // direction bits hard-wired to output
  function automatic logic [REG_W-1:0] fixed_out(input int b);
    return (b == 0) ? 32'h0000_0180 : 32'h0;
  endfunction

  // one latch bit under an active-low keep flag
  function automatic logic merge_bit(input logic old, input logic keep, input logic d);
    return keep ? old : d;
  endfunction

  function automatic int lo_ofs(input int b);
    return DATA_STRIDE * b;
  endfunction

  function automatic int hi_ofs(input int b);
    return DATA_STRIDE * b + 4;
  endfunction

  function automatic int ro_ofs(input int b);
    return RO_BASE + RO_STRIDE * b;
  endfunction

  function automatic int ctl_ofs(input int base, input int b);
    return base + CTL_STRIDE * b;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_banked_pkg::*;
#(
  parameter int           W     = 32,
  parameter logic [W-1:0] FIXED = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] wdata,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_dir,
  input  logic             wr_oe,
  input  logic             wr_ien,
  input  logic             wr_idis,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     lat_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     oe_q,
  output logic [W-1:0]     imask_q,
  output logic [W-1:0]     rb_q,
  output logic [W-1:0]     pad_oe
);

  logic [W-1:0] lat_d;
  logic [W-1:0] wbits;
  logic [W-1:0] drive_en;
  logic [W-1:0] rb_raw;

  assign wbits = wdata[W-1:0];

  // masked half-word update: keep flags in the upper half of the word
  always_comb begin
    lat_d = lat_q;
    for (int i = 0; i < W; i++) begin
      if ((i < HALF_W) ? wr_lo : wr_hi)
        lat_d[i] = merge_bit(lat_q[i], wdata[HALF_W + (i % HALF_W)], wdata[i % HALF_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      dir_q   <= FIXED;
      oe_q    <= '0;
      imask_q <= '1;
    end else begin
      lat_q <= lat_d;
      if (wr_dir)  dir_q   <= wbits | FIXED;
      if (wr_oe)   oe_q    <= wbits;
      if (wr_ien)       imask_q <= imask_q & ~wbits;
      else if (wr_idis) imask_q <= imask_q | wbits;
    end
  end

  assign drive_en = dir_q & oe_q;
  assign pad_oe   = drive_en;
  assign rb_raw   = (drive_en & lat_q) | (~drive_en & pad_in);

  gpio_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rb_raw),
    .q     (rb_q)
  );

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_banked_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int ADDR_W    = 12,
  localparam int NPINS     = total_pins(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  // per-bank write events, visible to the checker
  logic [NUM_BANKS-1:0] ev_lo, ev_hi, ev_dir, ev_oe, ev_ien, ev_idis;
  logic [REG_W-1:0]     rd_slot [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int               BW   = bank_pins(b);
    localparam int               BASE = pin_base(b);
    localparam logic [REG_W-1:0] FX   = fixed_out(b);

    logic [BW-1:0] lat, dir, oe, imask, rb, poe;

    assign ev_lo[b]   = wr_en && (addr == ADDR_W'(lo_ofs(b)));
    assign ev_hi[b]   = wr_en && (addr == ADDR_W'(hi_ofs(b)));
    assign ev_dir[b]  = wr_en && (addr == ADDR_W'(ctl_ofs(DIR_BASE, b)));
    assign ev_oe[b]   = wr_en && (addr == ADDR_W'(ctl_ofs(OE_BASE, b)));
    assign ev_ien[b]  = wr_en && (addr == ADDR_W'(ctl_ofs(IEN_BASE, b)));
    assign ev_idis[b] = wr_en && (addr == ADDR_W'(ctl_ofs(IDIS_BASE, b)));

    gpio_bank #(.W(BW), .FIXED(FX[BW-1:0])) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wdata   (wdata),
      .wr_lo   (ev_lo[b]),
      .wr_hi   (ev_hi[b]),
      .wr_dir  (ev_dir[b]),
      .wr_oe   (ev_oe[b]),
      .wr_ien  (ev_ien[b]),
      .wr_idis (ev_idis[b]),
      .pad_in  (pin_in[BASE +: BW]),
      .lat_q   (lat),
      .dir_q   (dir),
      .oe_q    (oe),
      .imask_q (imask),
      .rb_q    (rb),
      .pad_oe  (poe)
    );

    assign pin_out[BASE +: BW] = lat;
    assign pin_oe[BASE +: BW]  = poe;

    always_comb begin
      rd_slot[b] = '0;
      if (addr == ADDR_W'(ro_ofs(b)))                       rd_slot[b] = REG_W'(rb);
      else if (addr == ADDR_W'(ctl_ofs(DIR_BASE, b)))   rd_slot[b] = REG_W'(dir);
      else if (addr == ADDR_W'(ctl_ofs(OE_BASE, b)))    rd_slot[b] = REG_W'(oe);
      else if (addr == ADDR_W'(ctl_ofs(IMASK_BASE, b))) rd_slot[b] = REG_W'(imask);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en)
      for (int b = 0; b < NUM_BANKS; b++) rdata = rdata | rd_slot[b];
  end

endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int NPINS     = 118
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wr_en,
  input logic [31:0]          wdata,
  input logic                 rd_en,
  input logic [31:0]          rdata,
  input logic [NPINS-1:0]     pin_out,
  input logic [NPINS-1:0]     pin_oe,
  input logic [NUM_BANKS-1:0] ev_lo,
  input logic [NUM_BANKS-1:0] ev_hi,
  input logic [NUM_BANKS-1:0] ev_dir,
  input logic [NUM_BANKS-1:0] ev_oe,
  input logic [NUM_BANKS-1:0] ev_ien,
  input logic [NUM_BANKS-1:0] ev_idis
);

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 32'h0);

  a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_lo, ev_hi, ev_dir, ev_oe, ev_ien, ev_idis}));

  a_r2_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'('h000)) |-> rdata == 32'h0);

  a_r7_fixed_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'('h204)) |-> rdata[8:7] == 2'b11);

  a_r9_bank1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == ADDR_W'('h064) || addr == ADDR_W'('h244) ||
               addr == ADDR_W'('h248) || addr == ADDR_W'('h24C))) |-> rdata[31:22] == 10'h0);

  a_r3_masked_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h000)) |=>
      pin_out[15:0] == (($past(pin_out[15:0]) & $past(wdata[31:16])) |
                        ($past(wdata[15:0]) & ~$past(wdata[31:16]))));

  a_r6_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe));

  a_r6_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out));

endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .NPINS     (NPINS)
) u_chk (.*);

// File: tb/test_gpio_banked_ctrl.sv
`timescale 1ns/1ps
module test_gpio_banked_ctrl;

  localparam int NP = 118;

  typedef struct packed {
    logic        wr;
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h204, 32'hFFFF_FFFF, 12'h204, 32'hFFFF_FFFF, 4'd5},  // R5
    '{1'b1, 12'h208, 32'h0000_FFFF, 12'h208, 32'h0000_FFFF, 4'd6},  // R6
    '{1'b1, 12'h000, 32'hFF00_00AA, 12'h060, 32'h0000_00AA, 4'd3},  // R3
    '{1'b1, 12'h000, 32'hFFFE_5555, 12'h060, 32'h0000_00AB, 4'd3},  // R3 keep flags
    '{1'b1, 12'h004, 32'h0000_1234, 12'h060, 32'h0000_00AB, 4'd6},  // R6 gated upper half
    '{1'b1, 12'h208, 32'hFFFF_FFFF, 12'h060, 32'h1234_00AB, 4'd4},  // R4
    '{1'b1, 12'h204, 32'h0000_0000, 12'h204, 32'h0000_0180, 4'd7},  // R7
    '{1'b0, 12'h000, 32'h0,         12'h060, 32'h0000_0080, 4'd7},  // R7 pins 7,8 drive
    '{1'b1, 12'h244, 32'hFFFF_FFFF, 12'h244, 32'h003F_FFFF, 4'd9},  // R9
    '{1'b1, 12'h00C, 32'h0000_FFFF, 12'h064, 32'h0000_0000, 4'd6},  // R6 no enable yet
    '{1'b1, 12'h248, 32'hFFFF_FFFF, 12'h064, 32'h003F_0000, 4'd9},  // R9
    '{1'b1, 12'h018, 32'h0000_C3C3, 12'h06C, 32'h0000_0000, 4'd4},  // R4 bank3 input
    '{1'b1, 12'h2C4, 32'h0000_FFFF, 12'h2C4, 32'h0000_FFFF, 4'd5},  // R5
    '{1'b1, 12'h2C8, 32'h0000_FFFF, 12'h06C, 32'h0000_C3C3, 4'd4},  // R4
    '{1'b1, 12'h210, 32'h0000_F00F, 12'h20C, 32'hFFFF_0FF0, 4'd8},  // R8
    '{1'b1, 12'h214, 32'h0000_0003, 12'h20C, 32'hFFFF_0FF3, 4'd8},  // R8
    '{1'b1, 12'h250, 32'hFFFF_FFFF, 12'h24C, 32'h0000_0000, 4'd8},  // R8
    '{1'b1, 12'h254, 32'hFFC0_0001, 12'h24C, 32'h0000_0001, 4'd9},  // R9
    '{1'b0, 12'h000, 32'h0,         12'h000, 32'h0000_0000, 4'd2},  // R2
    '{1'b0, 12'h000, 32'h0,         12'h210, 32'h0000_0000, 4'd8},  // R8 write-only
    '{1'b1, 12'h060, 32'hFFFF_FFFF, 12'h060, 32'h0000_0080, 4'd11}, // R11
    '{1'b1, 12'h20C, 32'h0000_0000, 12'h20C, 32'hFFFF_0FF3, 4'd11}, // R11
    '{1'b1, 12'h300, 32'hFFFF_FFFF, 12'h300, 32'h0000_0000, 4'd11}  // R11
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic          rd_en = 1'b0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_banked_ctrl i_gpio_banked_ctrl (
    .clk, .rst_n, .addr, .wr_en, .wdata, .rd_en, .rdata, .pin_in, .pin_out, .pin_oe
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] r);
    addr = a; rd_en = 1'b1;
    #1;
    r = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    bus_rd(12'h204, r); chk("R10 dir0 reset", r, 32'h0000_0180);
    bus_rd(12'h208, r); chk("R10 oe0 reset", r, 32'h0);
    bus_rd(12'h20C, r); chk("R10 imask0 reset", r, 32'hFFFF_FFFF);
    bus_rd(12'h24C, r); chk("R10 imask1 reset", r, 32'h003F_FFFF);
    bus_rd(12'h060, r); chk("R10 data0 reset", r, 32'h0);
    chk("R10 pin_out reset", 32'(pin_out != '0), 32'h0);
    chk("R10 pin_oe reset", 32'(pin_oe != '0), 32'h0);
    chk("R11 idle rdata", rdata, 32'h0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) bus_wr(VECS[k].wa, VECS[k].wd);
      else @(negedge clk);
      repeat (3) @(negedge clk);
      bus_rd(VECS[k].ra, r);
      chk($sformatf("R%0d vector %0d", VECS[k].req, k), r, VECS[k].ex);
    end

    // R1 pin packing across banks
    chk("R1 bank1 pin_out", 32'(pin_out[53:32]), 32'h003F_0000);
    chk("R1 bank0 pin_oe", pin_oe[31:0], 32'h0000_0180);
    chk("R1 bank1 pin_oe", 32'(pin_oe[53:32]), 32'h003F_FFFF);
    chk("R1 bank3 pin_out", 32'(pin_out[101:86]), 32'h0000_C3C3);
    chk("R1 bank0 pin_out", pin_out[31:0], 32'h1234_00AB);

    // R4 two-flop latency on bank2 pin 3 (global 57)
    @(negedge clk);
    pin_in[57] = 1'b1;
    bus_rd(12'h068, r); chk("R4 sync edge0", r, 32'h0);
    @(negedge clk);
    bus_rd(12'h068, r); chk("R4 sync edge1", r, 32'h0);
    @(negedge clk);
    bus_rd(12'h068, r); chk("R4 sync edge2", r, 32'h0000_0008);

    // R4 driven pin reads latch, not input (bank1 pin 0, global 32)
    pin_in[32] = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(12'h064, r); chk("R4 output readback", r, 32'h003F_0000);

    // R3 masked write and input edge on the same edge
    @(negedge clk);
    addr = 12'h000; wdata = 32'hFE7F_0100; wr_en = 1'b1; pin_in[2] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3 pins 8:7 after write", 32'(pin_out[8:7]), 32'h2);
    bus_rd(12'h060, r); chk("R4 collide edge1", r, 32'h0000_0080);
    @(negedge clk);
    bus_rd(12'h060, r); chk("R4 collide edge2", r, 32'h0000_0084);
    @(negedge clk);
    bus_rd(12'h060, r); chk("R4 collide edge3", r, 32'h0000_0104);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule